// File: doc/BRIEF.md
# Indexed Audio Codec Register Interface

This block is the host-facing register front end of an audio codec. A host reaches it through four byte-wide ports. One port selects an indirect register. One port reads or writes the selected register. One port holds the interrupt status, and one port is a programmed-I/O data port. Behind the index port sits a bank of 32 indirect 8-bit configuration registers. The mode bit in indirect register 12 decides whether 16 or all 32 of them can be reached.

The block gives each register its reset value and applies a per-register write policy. Reserved and read-only registers are protected, and the mode register has only one writable bit. Format writes are gated by the mode-change-enable bits. The block also emulates the autocalibration-in-progress flag that a driver polls after it raises mode-change-enable. It drives three signals toward the rest of the codec: a playback-enable level, a one-cycle format-update strobe that carries the accepted format byte, and an interrupt line. A playback-done pulse from the audio datapath raises the interrupt line, and the host clears it.

Top module: `codec_regif`

## Requirements
- R1: After reset: the index port reads 0x40 and the status port reads 0x00. `irq` and `play_en` are 0. The indirect registers read as follows: 2, 3, 4, 5, 18 and 19 read 0x88; 6 and 7 read 0x80; 9 reads 0x08; 12 reads 0x8A; 25 and 26 read 0xA0; all others read 0x00.
- R2: Port 0 (index) never stores bit 7 of a written byte, and a read of port 0 always returns bit 7 as 0. Bit 6 of the index is the mode-change-enable (MCE) bit.
- R3: While bit 6 of register 12 is 0, port 1 (data) addresses indirect register index[3:0]. While that bit is 1, it addresses index[4:0].
- R4: A write to register 12 changes only its bit 6. The other bits keep their reset pattern, so the register reads 0x8A or 0xCA.
- R5: Writes to registers 22, 27 and 29 (reserved) and to register 11 (read-only error status) leave their read value unchanged.
- R6: A write to register 8 (format) while MCE is set stores the byte. One cycle later, `fmt_upd` pulses for exactly one cycle with `fmt_byte` equal to the byte.
- R7: While MCE is clear, a write to register 8 is accepted only if bit 4 of register 24 (playback MCE) is set. It then stores {new[7:4], old[3:0]} and strobes `fmt_upd` with that value. With both MCE bits clear, the write is dropped and there is no strobe.
- R8: A write to register 9 stores the byte with bit 5 forced to 0. `play_en` equals bit 0 of register 9.
- R9: A port 0 write that raises MCE from 0 to 1 while register 9 bits 4:3 are not both 0 loads a counter with CAL_READS. Each port 1 read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter. When the counter is zero, bit 5 reads 0. If bits 4:3 are both 0, the raise does not load the counter.
- R10: A one-cycle `pb_done` pulse sets status bit 0, sets bit 4 of register 24 and raises `irq`. If it coincides with a clear, the set wins.
- R11: Any write to port 2 (status) clears status bit 0, clears bits 6:4 of register 24 and drops `irq`.
- R12: A write to register 24 that takes bit 4 from 1 to 0 clears status bit 0 and drops `irq`. A write that leaves bit 4 at 1 does not.
- R13: Port 2 reads {7'b0, interrupt flag}. Port 3 (programmed-I/O) always reads 0x00, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Port select: 0 index, 1 data, 2 status, 3 programmed-I/O |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, registered, valid the cycle after the access |
| pb_done | input | 1 | Playback block-done event from the datapath |
| play_en | output | 1 | Playback enable level |
| fmt_upd | output | 1 | One-cycle strobe when a format write is accepted |
| fmt_byte | output | 8 | Accepted format byte, valid with `fmt_upd` |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted index or mode bit shows up on the very next data-port read: the data comes from the wrong indirect register, which the bench exposes by aliasing index 0x13 onto register 3 or register 19. A wrong write policy shows up within one access. This covers a reserved register or the mode register that accepts a byte, bit 5 of register 9 kept, or a format byte merged the wrong way; the cause is then visible in the read-back or the `fmt_byte` value. A calibration counter that loads wrongly or does not count down changes bit 5 of the error-status reads, and the bench counts those reads exactly. A stuck interrupt flag is seen on `irq` and the status port one cycle after the clearing write.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

  localparam int NREG = 32;
  localparam int IW   = $clog2(NREG);

  localparam logic [1:0] PORT_IDX  = 2'd0;
  localparam logic [1:0] PORT_DATA = 2'd1;
  localparam logic [1:0] PORT_STAT = 2'd2;
  localparam logic [1:0] PORT_PIO  = 2'd3;

  localparam logic [IW-1:0] RI_FMT   = IW'(8);
  localparam logic [IW-1:0] RI_CFG   = IW'(9);
  localparam logic [IW-1:0] RI_ERRST = IW'(11);
  localparam logic [IW-1:0] RI_MODE  = IW'(12);
  localparam logic [IW-1:0] RI_RSV0  = IW'(22);
  localparam logic [IW-1:0] RI_FEAT  = IW'(24);
  localparam logic [IW-1:0] RI_RSV1  = IW'(27);
  localparam logic [IW-1:0] RI_RSV2  = IW'(29);

  localparam logic [7:0] MODE_FIXED = 8'h8A;
  localparam logic [7:0] MODE_WMASK = 8'h40;

  function automatic logic [7:0] ireg_reset(input int i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return MODE_FIXED;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/codec_cal_cnt.sv
module codec_cal_cnt #(
  parameter int CAL_READS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic busy
);
  localparam int CW = $clog2(CAL_READS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CW'(CAL_READS);
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_cal_load_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == CW'(CAL_READS)));

  p_cal_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/codec_wr_policy.sv
module codec_wr_policy
  import codec_regif_pkg::*;
(
  input  logic          wr_en,
  input  logic [IW-1:0] iaddr,
  input  logic [7:0]    wval,
  input  logic [7:0]    old_val,
  input  logic          mce,
  input  logic          pmce,
  output logic          we,
  output logic [7:0]    eff_val,
  output logic          fmt_stb,
  output logic          pi_ack
);
  always_comb begin
    we      = 1'b0;
    eff_val = wval;
    fmt_stb = 1'b0;
    pi_ack  = 1'b0;
    if (wr_en) begin
      case (iaddr)
        RI_RSV0, RI_RSV1, RI_RSV2, RI_ERRST: ;
        RI_FMT: begin
          if (mce) begin
            we      = 1'b1;
            fmt_stb = 1'b1;
          end else if (pmce) begin
            eff_val = {wval[7:4], old_val[3:0]};
            we      = 1'b1;
            fmt_stb = 1'b1;
          end
        end
        RI_CFG: begin
          we      = 1'b1;
          eff_val = wval & 8'hDF;
        end
        RI_MODE: begin
          we      = 1'b1;
          eff_val = (old_val & ~MODE_WMASK) | (wval & MODE_WMASK);
        end
        RI_FEAT: begin
          we     = 1'b1;
          pi_ack = old_val[4] & ~wval[4];
        end
        default: we = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/codec_ireg_bank.sv
module codec_ireg_bank
  import codec_regif_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          flag_clr,
  input  logic          pi_set,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdat,
  output logic          play_bit,
  output logic          cal_arm,
  output logic          mode2,
  output logic          pmce
);
  logic [7:0] regs_w [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic [7:0] q;
    if (gi == int'(RI_FEAT)) begin : g_feat
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= ireg_reset(gi);
        end else begin
          logic [7:0] nx;
          nx = q;
          if (we && waddr == IW'(gi)) nx = wdata;
          if (flag_clr) nx[6:4] = 3'b000;
          if (pi_set) nx[4] = 1'b1;
          q <= nx;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          q <= ireg_reset(gi);
        else if (we && waddr == IW'(gi))
          q <= wdata;
      end
    end
    assign regs_w[gi] = q;
  end

  assign rdat     = regs_w[raddr];
  assign play_bit = regs_w[RI_CFG][0];
  assign cal_arm  = (regs_w[RI_CFG][4:3] != 2'b00);
  assign mode2    = regs_w[RI_MODE][6];
  assign pmce     = regs_w[RI_FEAT][4];

  p_mode_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (regs_w[RI_MODE] & ~MODE_WMASK) == MODE_FIXED);

  p_errst_ro_r5: assert property (@(posedge clk) disable iff (rst)
    regs_w[RI_ERRST] == 8'h00);

  p_cfg_b5_r8: assert property (@(posedge clk) disable iff (rst)
    regs_w[RI_CFG][5] == 1'b0);

endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int CAL_READS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [1:0] acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic       pb_done,
  output logic       play_en,
  output logic       fmt_upd,
  output logic [7:0] fmt_byte,
  output logic       irq
);
  logic [6:0]    idx_q;
  logic          int_q;
  logic [7:0]    rdata_q;
  logic          fmt_upd_q;
  logic [7:0]    fmt_byte_q;

  logic          mce, mode2, pmce, cal_arm, play_bit, cal_busy;
  logic [IW-1:0] iaddr;
  logic [7:0]    ireg_rd;
  logic          wr_idx, wr_dat, wr_stat, rd_dat;
  logic          pol_we, pol_stb, pol_ack;
  logic [7:0]    pol_val;
  logic          cal_load, cal_dec;

  assign mce   = idx_q[6];
  assign iaddr = mode2 ? idx_q[IW-1:0] : {1'b0, idx_q[IW-2:0]};

  assign wr_idx  = acc_en &&  acc_wr && acc_addr == PORT_IDX;
  assign wr_dat  = acc_en &&  acc_wr && acc_addr == PORT_DATA;
  assign wr_stat = acc_en &&  acc_wr && acc_addr == PORT_STAT;
  assign rd_dat  = acc_en && !acc_wr && acc_addr == PORT_DATA;

  assign cal_load = wr_idx && !mce && acc_wdata[6] && cal_arm;
  assign cal_dec  = rd_dat && iaddr == RI_ERRST;

  codec_wr_policy u_pol (
    .wr_en   (wr_dat),
    .iaddr   (iaddr),
    .wval    (acc_wdata),
    .old_val (ireg_rd),
    .mce     (mce),
    .pmce    (pmce),
    .we      (pol_we),
    .eff_val (pol_val),
    .fmt_stb (pol_stb),
    .pi_ack  (pol_ack)
  );

  codec_ireg_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .we       (pol_we),
    .waddr    (iaddr),
    .wdata    (pol_val),
    .flag_clr (wr_stat),
    .pi_set   (pb_done),
    .raddr    (iaddr),
    .rdat     (ireg_rd),
    .play_bit (play_bit),
    .cal_arm  (cal_arm),
    .mode2    (mode2),
    .pmce     (pmce)
  );

  codec_cal_cnt #(.CAL_READS(CAL_READS)) u_cal (
    .clk  (clk),
    .rst  (rst),
    .load (cal_load),
    .dec  (cal_dec),
    .busy (cal_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= 7'h40;
      int_q      <= 1'b0;
      rdata_q    <= 8'h00;
      fmt_upd_q  <= 1'b0;
      fmt_byte_q <= 8'h00;
    end else begin
      if (wr_idx) idx_q <= acc_wdata[6:0];

      if (pb_done)                int_q <= 1'b1;
      else if (wr_stat || pol_ack) int_q <= 1'b0;

      fmt_upd_q <= pol_stb;
      if (pol_stb) fmt_byte_q <= pol_val;

      if (acc_en && !acc_wr) begin
        case (acc_addr)
          PORT_IDX:  rdata_q <= {1'b0, idx_q};
          PORT_DATA: rdata_q <= ireg_rd | ((iaddr == RI_ERRST && cal_busy) ? 8'h20 : 8'h00);
          PORT_STAT: rdata_q <= {7'b0, int_q};
          default:   rdata_q <= 8'h00;
        endcase
      end
    end
  end

  assign acc_rdata = rdata_q;
  assign play_en   = play_bit;
  assign fmt_upd   = fmt_upd_q;
  assign fmt_byte  = fmt_byte_q;
  assign irq       = int_q;

  p_idx_b7_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && acc_addr == PORT_IDX) |=> !acc_rdata[7]);

  p_fmt_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_dat && iaddr == RI_FMT && !mce && !pmce) |=> !fmt_upd);

  p_done_irq_r10: assert property (@(posedge clk) disable iff (rst)
    pb_done |=> irq);

  p_stat_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !pb_done) |=> !irq);

endmodule

// File: tb/codec_regif_bench.sv
`timescale 1ns/1ps
module codec_regif_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_en = 1'b0, acc_wr = 1'b0;
  logic [1:0] acc_addr = 2'd0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       pb_done = 1'b0;
  logic       play_en, fmt_upd, irq;
  logic [7:0] fmt_byte;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic       seen_upd;
  logic [7:0] seen_byte;

  always #4 clk = ~clk;

  codec_regif #(.CAL_READS(2)) u_codec_regif (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .pb_done(pb_done),
    .play_en(play_en), .fmt_upd(fmt_upd), .fmt_byte(fmt_byte), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    seen_upd = fmt_upd; seen_byte = fmt_byte;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    d = acc_rdata;
  endtask

  task automatic rd_ind(input logic [7:0] idx, output logic [7:0] d);
    wr(2'd0, idx);
    rd(2'd1, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v);       chk("R1 index", v, 8'h40);
    rd_ind(8'h42, v);  chk("R1 reg2", v, 8'h88);
    rd_ind(8'h46, v);  chk("R1 reg6", v, 8'h80);
    rd_ind(8'h49, v);  chk("R1 reg9", v, 8'h08);
    rd_ind(8'h4C, v);  chk("R1 reg12", v, 8'h8A);
    rd_ind(8'h40, v);  chk("R1 reg0", v, 8'h00);
    rd(2'd2, v);       chk("R1 status", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 play_en", {7'b0, play_en}, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] v;
    wr(2'd0, 8'hC5);
    rd(2'd0, v); chk("R2 bit7 dropped", v, 8'h45);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wr(2'd0, 8'h43); wr(2'd1, 8'h5A);
    rd_ind(8'h53, v); chk("R3 4-bit alias to reg3", v, 8'h5A);
    wr(2'd0, 8'h4C); wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R4 mode set", v, 8'hCA);
    rd_ind(8'h53, v); chk("R3 5-bit reaches reg19", v, 8'h88);
    wr(2'd0, 8'h56); wr(2'd1, 8'h77);
    rd(2'd1, v); chk("R5 reg22 ignored", v, 8'h00);
    wr(2'd0, 8'h5B); wr(2'd1, 8'h77);
    rd(2'd1, v); chk("R5 reg27 ignored", v, 8'h00);
    wr(2'd0, 8'h5D); wr(2'd1, 8'h77);
    rd(2'd1, v); chk("R5 reg29 ignored", v, 8'h00);
    wr(2'd0, 8'h4B); wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R5 reg11 read-only", v, 8'h00);
    wr(2'd0, 8'h4C); wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R4 mode clear", v, 8'h8A);
  endtask

  task automatic t_format();
    logic [7:0] v;
    wr(2'd0, 8'h48); wr(2'd1, 8'h5C);
    chk("R6 strobe", {7'b0, seen_upd}, 8'h01);
    chk("R6 byte", seen_byte, 8'h5C);
    @(negedge clk); chk("R6 one cycle", {7'b0, fmt_upd}, 8'h00);
    rd(2'd1, v); chk("R6 stored", v, 8'h5C);
    wr(2'd0, 8'h08); wr(2'd1, 8'hA3);
    chk("R7 dropped no strobe", {7'b0, seen_upd}, 8'h00);
    rd(2'd1, v); chk("R7 dropped value", v, 8'h5C);
    wr(2'd0, 8'h0C); wr(2'd1, 8'h40);
    wr(2'd0, 8'h18); wr(2'd1, 8'h10);
    wr(2'd0, 8'h08); wr(2'd1, 8'hA3);
    chk("R7 pmce strobe", {7'b0, seen_upd}, 8'h01);
    chk("R7 pmce byte", seen_byte, 8'hAC);
    rd(2'd1, v); chk("R7 pmce merge", v, 8'hAC);
    wr(2'd0, 8'h18); wr(2'd1, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] v;
    wr(2'd0, 8'h09); wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R8 bit5 forced", v, 8'hDF);
    chk("R8 play_en on", {7'b0, play_en}, 8'h01);
    wr(2'd1, 8'h08);
    chk("R8 play_en off", {7'b0, play_en}, 8'h00);
  endtask

  task automatic t_cal();
    logic [7:0] v;
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
    rd(2'd1, v); chk("R9 cal read 1", v, 8'h20);
    rd(2'd1, v); chk("R9 cal read 2", v, 8'h20);
    rd(2'd1, v); chk("R9 cal expired", v, 8'h00);
    wr(2'd0, 8'h09); wr(2'd1, 8'h00);
    wr(2'd0, 8'h4B);
    rd(2'd1, v); chk("R9 no load when unarmed", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    @(negedge clk); pb_done = 1'b1; @(negedge clk); pb_done = 1'b0;
    chk("R10 irq set", {7'b0, irq}, 8'h01);
    rd(2'd2, v); chk("R10 status bit0", v, 8'h01);
    rd_ind(8'h18, v); chk("R10 reg24 bit4", v, 8'h10);
    wr(2'd1, 8'h30);
    chk("R12 bit4 kept irq stays", {7'b0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    chk("R11 irq cleared", {7'b0, irq}, 8'h00);
    rd(2'd2, v); chk("R11 status cleared", v, 8'h00);
    rd(2'd1, v); chk("R11 reg24 bits cleared", v, 8'h00);
    @(negedge clk); pb_done = 1'b1; @(negedge clk); pb_done = 1'b0;
    wr(2'd1, 8'h00);
    chk("R12 ack clears irq", {7'b0, irq}, 8'h00);
    rd(2'd2, v); chk("R12 ack clears status", v, 8'h00);
  endtask

  task automatic t_pio();
    logic [7:0] v;
    wr(2'd3, 8'hAB);
    rd(2'd3, v); chk("R13 pio reads zero", v, 8'h00);
    rd(2'd0, v); chk("R13 pio write no effect on index", v, 8'h18);
    rd(2'd2, v); chk("R13 status read", v, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_index();
    t_mode();
    t_format();
    t_config();
    t_cal();
    t_irq();
    t_pio();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule